// File: doc/BRIEF.md
# Self-Timed Word Programming Controller

This block sits behind a serial command front end and carries out decoded commands on a small non-volatile style store: a register array of `DEPTH` words of `DATA_W` bits, held in flip-flops. The front end presents one command per strobe (opcode, word address, data word). Enable and disable commands act on a programming-enable latch at once. An erase, a write, an erase-all or a write-all is held armed until chip select falls. That falling edge starts a self-timed cycle of `PROG_CYCLES` system clocks. When the cycle ends, the array is updated.

Stored bits follow erase-before-write rules. Erase drives bits to 1. A write can only clear bits, so the new word is the old word ANDed with the supplied data. The front end drives the shared data-out pin from `sts_oe` / `sts_val` while a cycle is active. With chip select high, the pin shows 0 while the cycle runs and 1 once the cycle is complete. Reads go through a separate combinational port that the front end shifts out on its own.

Top module: `nvw_prog_ctrl`

## Requirements
- R1: After reset every word reads 16'hFFFF, the enable latch is clear and `sts_oe` is 0 even with `cs` high.
- R2: With the enable latch clear, an erase (`cmd_op`=2), write (3), erase-all (4) or write-all (5) is dropped. No word changes, and raising `cs` after a falling edge drives no status (`sts_oe`=0).
- R3: Enable (`cmd_op`=6) sets the latch and disable (7) clears it. The latch keeps its value until the other command or a reset.
- R4: `rd_data` equals the word at `rd_addr` in the same cycle, whatever the latch state. Read (1) and no-op (0) commands change nothing.
- R5: Erase sets the addressed word to all ones. Erase-all sets every word to all ones.
- R6: Write stores `old & cmd_data` at the addressed word. Write-all stores `old & cmd_data` into every word.
- R7: An accepted programming command starts its cycle on the first clock that sees `cs` low after it was high. The array commits exactly `PROG_CYCLES` clocks after that edge.
- R8: While the cycle runs and `cs` is high, `sts_oe`=1 and `sts_val`=0. In the clock of the commit and afterwards, `sts_val`=1 whenever `cs` is high, including when `cs` stayed low through the whole cycle.
- R9: Every command strobed during a running cycle is ignored, including enable and disable.
- R10: After the cycle has finished, the next falling edge of `cs` releases the status. From then on `sts_oe` stays 0 until another cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Opcode: 0 nop, 1 read, 2 erase, 3 write, 4 erase-all, 5 write-all, 6 enable, 7 disable |
| cmd_addr | input | ADDR_W (6) | Target word address |
| cmd_data | input | DATA_W (16) | Data for write and write-all |
| cs | input | 1 | Chip select, sampled on clk |
| rd_addr | input | ADDR_W (6) | Read port address |
| rd_data | output | DATA_W (16) | Word at `rd_addr` |
| sts_oe | output | 1 | Drive data-out with the status bit |
| sts_val | output | 1 | Status bit: 0 busy, 1 ready |

## Verification
The bench builds the block with `PROG_CYCLES` = 20 and keeps the default 64 x 16 array. A full programming cycle then fits in a few dozen clocks, so the exact commit clock, the busy-to-ready change, a strobe landing mid-cycle and the release on the next falling edge can all be checked in one short run. At this depth the first word, the last word and a write-all that touches every word are all covered by ordinary read-backs.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

  // Command opcodes presented by the serial front end.
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_ERASE = 3'd2,
    OP_WRITE = 3'd3,
    OP_ERALL = 3'd4,
    OP_WRALL = 3'd5,
    OP_EN    = 3'd6,
    OP_DIS   = 3'd7
  } nvw_op_e;

  // Programming cycle phases.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BUSY  = 2'd2,
    ST_DONE  = 2'd3
  } nvw_state_e;

  function automatic logic op_is_prog(nvw_op_e op);
    return (op == OP_ERASE) || (op == OP_WRITE) || (op == OP_ERALL) || (op == OP_WRALL);
  endfunction

  function automatic logic op_is_erase(nvw_op_e op);
    return (op == OP_ERASE) || (op == OP_ERALL);
  endfunction

  function automatic logic op_is_global(nvw_op_e op);
    return (op == OP_ERALL) || (op == OP_WRALL);
  endfunction

endpackage

// File: rtl/nvw_enable_latch.sv
module nvw_enable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic clr_en,
  output logic en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (set_en) en_q <= 1'b1;
    else if (clr_en) en_q <= 1'b0;
  end

  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(en_q)); // R3
  AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> en_q); // R3
  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !en_q); // R3

endmodule

// File: rtl/nvw_cycle_fsm.sv
module nvw_cycle_fsm
  import nvw_pkg::*;
#(
  parameter int PROG_CYCLES = 1500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       arm_req,
  output logic       commit,
  output logic       busy,
  output logic       sts_oe,
  output logic       sts_val,
  output nvw_state_e state
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PROG_CYCLES - 1);

  logic             cs_q;
  logic             cs_fall;
  logic [CNT_W-1:0] timer_q;
  nvw_state_e       state_d;

  // Named internal events
  assign cs_fall = cs_q && !cs;
  assign busy    = (state == ST_BUSY);
  assign commit  = busy && (timer_q == '0);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (arm_req) state_d = ST_ARMED;
      ST_ARMED: if (!arm_req && cs_fall) state_d = ST_BUSY;
      ST_BUSY:  if (commit) state_d = ST_DONE;
      ST_DONE: begin
        if (arm_req)      state_d = ST_ARMED;
        else if (cs_fall) state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cs_q    <= 1'b0;
      timer_q <= '0;
    end else begin
      state <= state_d;
      cs_q  <= cs;
      if (state == ST_ARMED && state_d == ST_BUSY) timer_q <= LOAD_VAL;
      else if (busy && timer_q != '0)              timer_q <= timer_q - 1'b1;
    end
  end

  // Status pin: busy reads 0, finished reads 1, only while cs is high
  assign sts_oe  = cs && (busy || state == ST_DONE);
  assign sts_val = (state == ST_DONE);

  // Checker-only cycle length counter
  logic [CNT_W-1:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (busy_len == LOAD_VAL)); // R7
  AST_READY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (sts_val && (sts_oe == cs))); // R8
  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !arm_req && cs_q && !cs) |=> busy); // R7
  AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !arm_req && cs_fall) |=> !sts_oe); // R10

endmodule

// File: rtl/nvw_word_array.sv
module nvw_word_array
  import nvw_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  nvw_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  // Erase drives ones; a write only clears bits.
  function automatic logic [DATA_W-1:0] next_word(nvw_op_e o, logic [DATA_W-1:0] old_w,
                                                   logic [DATA_W-1:0] new_w);
    if (op_is_erase(o)) return '1;
    return old_w & new_w;
  endfunction

  logic [DEPTH-1:0][DATA_W-1:0] words;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] word_q;

    assign hit      = commit && (op_is_global(op) || addr == ADDR_W'(g));
    assign words[g] = word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '1;
      else if (hit) word_q <= next_word(op, word_q, data);
    end

    AST_BITS_ONLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && op_is_erase(op)) |=> ((word_q & ~$past(word_q)) == '0)); // R6
    AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && op_is_erase(op)) |=> (word_q == '1)); // R5
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/nvw_prog_ctrl.sv
module nvw_prog_ctrl
  import nvw_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1500000,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cs,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sts_oe,
  output logic              sts_val
);

  nvw_op_e    op_in;
  nvw_state_e state;
  logic       busy;
  logic       commit;
  logic       en_q;
  logic       cmd_take;
  logic       set_en;
  logic       clr_en;
  logic       prog_take;

  nvw_op_e           pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  // Command acceptance: nothing is taken while a cycle runs
  assign op_in     = nvw_op_e'(cmd_op);
  assign cmd_take  = cmd_valid && !busy;
  assign set_en    = cmd_take && (op_in == OP_EN);
  assign clr_en    = cmd_take && (op_in == OP_DIS);
  assign prog_take = cmd_take && op_is_prog(op_in) && en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_op   <= OP_NOP;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (prog_take) begin
      pend_op   <= op_in;
      pend_addr <= cmd_addr;
      pend_data <= cmd_data;
    end
  end

  nvw_enable_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (set_en),
    .clr_en (clr_en),
    .en_q   (en_q)
  );

  nvw_cycle_fsm #(.PROG_CYCLES(PROG_CYCLES)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .arm_req (prog_take),
    .commit  (commit),
    .busy    (busy),
    .sts_oe  (sts_oe),
    .sts_val (sts_val),
    .state   (state)
  );

  nvw_word_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .op      (pend_op),
    .addr    (pend_addr),
    .data    (pend_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(en_q) && $stable(pend_op) && $stable(pend_addr))); // R9
  AST_NO_PROG_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cmd_valid && op_is_prog(op_in) && !en_q) |=> (state == ST_IDLE)); // R2
  AST_COMMIT_ONLY_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> op_is_prog(pend_op)); // R7

endmodule

// File: tb/nvw_prog_ctrl_tb_top.sv
module nvw_prog_ctrl_tb_top;

  localparam int DEPTH  = 64;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int NCYC   = 20;

  localparam logic [2:0] C_ERASE = 3'd2, C_WRITE = 3'd3, C_ERALL = 3'd4,
                         C_WRALL = 3'd5, C_EN = 3'd6, C_DIS = 3'd7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_data = '0;
  logic              cs = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              sts_oe;
  logic              sts_val;

  always #5 clk = ~clk;

  nvw_prog_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PROG_CYCLES(NCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cs(cs), .rd_addr(rd_addr),
    .rd_data(rd_data), .sts_oe(sts_oe), .sts_val(sts_val)
  );

  int  n_chk = 0;
  int  n_err = 0;
  bit  finished = 1'b0;

  logic [DATA_W-1:0] model [DEPTH];
  bit                model_en;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] exp;
    string             req;
  } sb_item_t;
  sb_item_t sb_q[$];

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compare each queued read once the address has settled
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() != 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check_eq($sformatf("%s word %0d", it.req, it.addr), {16'h0, rd_data}, {16'h0, it.exp});
      end
    end
  end

  // Driver: present an address and push the expectation from the model
  task automatic read_exp(int a, string req);
    sb_item_t it;
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    it.addr = ADDR_W'(a);
    it.exp  = model[a];
    it.req  = req;
    sb_q.push_back(it);
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    model_en = 1'b0;
  endtask

  task automatic send(logic [2:0] op, int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    cs = 1'b1; cmd_valid = 1'b1; cmd_op = op; cmd_addr = ADDR_W'(a); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == C_EN) model_en = 1'b1;
    if (op == C_DIS) model_en = 1'b0;
  endtask

  task automatic model_apply(logic [2:0] op, int a, logic [DATA_W-1:0] d);
    if (!model_en) return;
    case (op)
      C_ERASE: model[a] = '1;
      C_WRITE: model[a] = model[a] & d;
      C_ERALL: for (int i = 0; i < DEPTH; i++) model[i] = '1;
      C_WRALL: for (int i = 0; i < DEPTH; i++) model[i] = model[i] & d;
      default: ;
    endcase
  endtask

  // Cycle with status polled from the first clock, optional strobes mid-cycle
  task automatic cycle_polled(bit inject);
    @(negedge clk); cs = 1'b0;          // fall seen at next posedge P0
    @(negedge clk); cs = 1'b1; #1;      // after P0
    check_eq("R8 busy oe", {31'h0, sts_oe}, 32'h1);
    check_eq("R8 busy val", {31'h0, sts_val}, 32'h0);
    if (inject) begin
      @(negedge clk); cmd_valid = 1'b1; cmd_op = C_DIS;                     // R9
      @(negedge clk); cmd_valid = 1'b0;
      @(negedge clk); cmd_valid = 1'b1; cmd_op = C_WRITE; cmd_addr = 6'd9; cmd_data = '0;
      @(negedge clk); cmd_valid = 1'b0;
      repeat (NCYC - 5) @(negedge clk);
    end else begin
      repeat (NCYC - 1) @(negedge clk);
    end
    #1;
    check_eq("R7 still busy one clock before commit", {31'h0, sts_val}, 32'h0);
    @(negedge clk); #1;
    check_eq("R7 ready right after commit", {31'h0, sts_val}, 32'h1);
    check_eq("R8 ready oe", {31'h0, sts_oe}, 32'h1);
    @(negedge clk); cs = 1'b0;
    @(negedge clk); cs = 1'b1; #1;
    check_eq("R10 released after fall", {31'h0, sts_oe}, 32'h0);
    @(negedge clk); cs = 1'b0;
  endtask

  // Cycle with cs held low throughout; status looked at afterwards
  task automatic cycle_quiet(bit expect_run);
    @(negedge clk); cs = 1'b0;
    repeat (NCYC + 2) @(negedge clk);
    cs = 1'b1; #1;
    if (expect_run) begin
      check_eq("R8 ready after quiet cycle oe", {31'h0, sts_oe}, 32'h1);
      check_eq("R8 ready after quiet cycle val", {31'h0, sts_val}, 32'h1);
    end else begin
      check_eq("R2 no status when disabled", {31'h0, sts_oe}, 32'h0);
    end
    @(negedge clk); cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic prog(logic [2:0] op, int a, logic [DATA_W-1:0] d, int mode);
    bit run;
    run = model_en;
    send(op, a, d);
    model_apply(op, a, d);
    if (mode == 0)      cycle_quiet(run);
    else if (mode == 1) cycle_polled(1'b0);
    else                cycle_polled(1'b1);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); cs = 1'b1; #1;
    check_eq("R1 oe after reset", {31'h0, sts_oe}, 32'h0);
    cs = 1'b0;
    read_exp(0, "R1");
    read_exp(63, "R1");

    // R2 programming dropped while disabled
    prog(C_WRITE, 5, 16'h0000, 0);
    prog(C_ERALL, 0, 16'h0000, 0);
    read_exp(5, "R2");

    // R3 enable, then a polled write with strobes injected mid-cycle (R9)
    send(C_EN, 0, '0);
    prog(C_WRITE, 5, 16'h1234, 2);
    read_exp(5, "R6 write");
    read_exp(9, "R9 write during busy ignored");

    // R9 disable during busy was ignored: this write still lands; R6 AND
    prog(C_WRITE, 5, 16'hFF00, 0);
    read_exp(5, "R9 R6 and-write");

    // R5 single erase
    prog(C_ERASE, 5, '0, 1);
    read_exp(5, "R5 erase");

    // R6 write then write-all
    prog(C_WRITE, 3, 16'h0F0F, 0);
    prog(C_WRALL, 0, 16'hA5A5, 1);
    read_exp(3, "R6 write-all");
    read_exp(0, "R6 write-all");
    read_exp(63, "R6 write-all");

    // R3 disable blocks; R4 reads still work while disabled
    send(C_DIS, 0, '0);
    prog(C_WRITE, 7, 16'h0000, 0);
    read_exp(7, "R3 R4 disabled read");
    read_exp(3, "R4 disabled read");
    send(1'b1 ? 3'd1 : 3'd0, 3, '0);
    read_exp(3, "R4 read command no effect");

    // R5 erase-all after re-enable
    send(C_EN, 0, '0);
    prog(C_ERALL, 0, '0, 1);
    read_exp(3, "R5 erase-all");
    read_exp(40, "R5 erase-all");

    // R1 R3 reset clears the latch
    send(C_EN, 0, '0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_reset();
    prog(C_WRITE, 2, 16'h0000, 0);
    read_exp(2, "R1 R3 latch cleared by reset");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule